// File: doc/BRIEF.md
# Byte Nonvolatile Store Access Controller

This block sits between a small CPU and a 64-byte nonvolatile array, modelled here as plain registers. Software loads an address register and a data register, and then writes a control register. A control write either starts a read or, after a short timed unlock, starts a programming operation. A read copies the addressed byte into the data register. The programming operation runs in one of three modes: a full erase followed by a write, an erase alone, or a write alone. Cycle counters stand in for the timing of the storage cells.

While a programming operation runs, the block raises `busy` and refuses every register write and every read. Each accepted read or program start asserts `cpu_stall` for a fixed number of cycles. An erase leaves the byte at 0xFF. A write alone can only clear bits, so the stored value becomes the old byte ANDed with the new data. A target that was not erased first is therefore corrupted in a predictable way.

Top module: `nvbyte_ctrl`

## Requirements
- R1: After reset, `addr_q`, `data_q`, `mode_q`, `unlock_q`, `busy` and `cpu_stall` are all zero, and every array byte reads 0xFF.
- R2: A register write with `reg_we` high and `busy` low takes effect at the next clock edge. Select 0 loads `addr_q` from `reg_wdata[5:0]`. Select 1 loads `data_q`. Select 2 is the control register: bits 5:4 load `mode_q`, bit 2 requests unlock, bit 1 requests programming and bit 0 requests a read. Select 3 has no effect.
- R3: A control write with bit 2 set raises `unlock_q` for exactly 4 cycles, after which it clears by itself. Rewriting bit 2 reloads the 4-cycle window.
- R4: A programming request starts only if `unlock_q` is already high when the request is written, and only if the mode is not 11. The mode used is the one written in the same control write. A request that fails these conditions leaves `busy` low and the array unchanged. An accepted start clears `unlock_q`.
- R5: Mode 00 keeps `busy` high for ERASE_CYC+WRITE_CYC cycles, and the addressed byte then equals `data_q`.
- R6: Mode 01 keeps `busy` high for ERASE_CYC cycles, and the addressed byte then equals 0xFF.
- R7: Mode 10 keeps `busy` high for WRITE_CYC cycles, and the addressed byte then equals the old byte AND `data_q`.
- R8: While `busy` is high, register writes of every select, including reads and program requests, have no effect.
- R9: An accepted read (control bit 0 set, bit 1 clear) loads `data_q` with the addressed byte at the next edge and holds `cpu_stall` high for 4 cycles.
- R10: An accepted program start holds `cpu_stall` high for 2 cycles.
- R11: A program request with mode 11 is ignored. `mode_q` still takes the value 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 data, 2 control |
| reg_wdata | input | 8 | Register write data |
| addr_q | output | 6 | Address register |
| data_q | output | 8 | Data register, including read results |
| mode_q | output | 2 | Programming mode register |
| unlock_q | output | 1 | Unlock window open |
| busy | output | 1 | Programming in progress |
| cpu_stall | output | 1 | Stall request to the CPU |

## Verification
The assertions assume that `reg_we` and its select and data are driven cleanly between clock edges. They also assume that software sets both the program bit and the read bit only when it intends the program to take priority. The stimulus changes inputs only on falling edges and uses each control write for one purpose. It draws random addresses, data, modes and unlock-to-request gaps of 0 to 5 cycles, so that requests land both inside and outside the window. Directed cases then cover mode 11, requests without an unlock, and writes issued while `busy` is high.

// File: rtl/nvbyte_ctrl.sv
module nvbyte_ctrl #(
  parameter int DEPTH     = 64,
  parameter int DW        = 8,
  parameter int ERASE_CYC = 20,
  parameter int WRITE_CYC = 16,
  parameter int UNLK_WIN  = 4,
  parameter int RD_STALL  = 4,
  parameter int PG_STALL  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [1:0]               reg_sel,
  input  logic [7:0]               reg_wdata,
  output logic [$clog2(DEPTH)-1:0] addr_q,
  output logic [DW-1:0]            data_q,
  output logic [1:0]               mode_q,
  output logic                     unlock_q,
  output logic                     busy,
  output logic                     cpu_stall
);
  localparam int AW     = $clog2(DEPTH);
  localparam int TOTAL  = ERASE_CYC + WRITE_CYC;
  localparam int CW     = $clog2(TOTAL + 1);
  localparam int UW     = $clog2(UNLK_WIN + 1);
  localparam int SMAX   = (RD_STALL > PG_STALL) ? RD_STALL : PG_STALL;
  localparam int SW     = $clog2(SMAX + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] pcnt;
  logic [UW-1:0] ucnt;
  logic [SW-1:0] scnt;
  logic [1:0]    op_mode;

  wire [1:0] new_mode = reg_wdata[5:4];
  wire ctrl_wr = reg_we && !busy && (reg_sel == 2'd2);
  wire prog_go = ctrl_wr && reg_wdata[1] && unlock_q && (new_mode != 2'b11);
  wire rd_go   = ctrl_wr && reg_wdata[0] && !reg_wdata[1];
  wire done    = busy && (pcnt == '0);

  function automatic logic [CW-1:0] dur_of(input logic [1:0] m);
    case (m)
      2'b00:   dur_of = CW'(TOTAL - 1);
      2'b01:   dur_of = CW'(ERASE_CYC - 1);
      default: dur_of = CW'(WRITE_CYC - 1);
    endcase
  endfunction

  assign cpu_stall = (scnt != '0);

  // software registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      mode_q <= '0;
    end else if (reg_we && !busy) begin
      case (reg_sel)
        2'd0: addr_q <= reg_wdata[AW-1:0];
        2'd1: data_q <= reg_wdata[DW-1:0];
        2'd2: begin
          mode_q <= new_mode;
          if (rd_go) data_q <= mem[addr_q];
        end
        default: ;
      endcase
    end
  end

  // unlock window
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlock_q <= 1'b0;
      ucnt     <= '0;
    end else if (prog_go) begin
      unlock_q <= 1'b0;
      ucnt     <= '0;
    end else if (ctrl_wr && reg_wdata[2]) begin
      unlock_q <= 1'b1;
      ucnt     <= UW'(UNLK_WIN - 1);
    end else if (unlock_q) begin
      if (ucnt == '0) unlock_q <= 1'b0;
      else            ucnt <= ucnt - 1'b1;
    end
  end

  // programming sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      pcnt    <= '0;
      op_mode <= '0;
    end else if (prog_go) begin
      busy    <= 1'b1;
      pcnt    <= dur_of(new_mode);
      op_mode <= new_mode;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      pcnt <= pcnt - 1'b1;
    end
  end

  // array contents
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (done) begin
      case (op_mode)
        2'b00:   mem[addr_q] <= data_q;
        2'b01:   mem[addr_q] <= '1;
        default: mem[addr_q] <= mem[addr_q] & data_q;
      endcase
    end
  end

  // CPU stall
  always_ff @(posedge clk) begin
    if (!rst_n)       scnt <= '0;
    else if (prog_go) scnt <= SW'(PG_STALL);
    else if (rd_go)   scnt <= SW'(RD_STALL);
    else if (scnt != '0) scnt <= scnt - 1'b1;
  end

  assert_start_needs_unlock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(unlock_q));
  assert_start_clears_unlock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !unlock_q);
  assert_busy_freezes_regs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(addr_q) && $stable(data_q) && $stable(mode_q)));
  assert_start_stalls_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cpu_stall);
  assert_no_reserved_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mode_q != 2'b11));
  assert_unlock_no_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_q && !reg_we) |=> (ucnt <= $past(ucnt)));
endmodule

// File: tb/nvbyte_ctrl_test.sv
`timescale 1ns/1ps
module nvbyte_ctrl_test;
  localparam int ER = 20, WR = 16;
  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic [5:0] addr_q;
  logic [7:0] data_q;
  logic [1:0] mode_q;
  logic unlock_q, busy, cpu_stall;
  int checks = 0, fails = 0;
  logic [7:0] model [64];

  nvbyte_ctrl #(.ERASE_CYC(ER), .WRITE_CYC(WR)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .addr_q(addr_q), .data_q(data_q), .mode_q(mode_q), .unlock_q(unlock_q),
    .busy(busy), .cpu_stall(cpu_stall));

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int dur_exp(input int m);
    return (m == 0) ? ER + WR : (m == 1) ? ER : WR;
  endfunction

  function automatic logic [7:0] prog_exp(input int m, input logic [7:0] old, input logic [7:0] d);
    return (m == 0) ? d : (m == 1) ? 8'hFF : (old & d);
  endfunction

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    reg_we = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  function automatic logic [7:0] ctl(input int m, input bit u, input bit p, input bit r);
    return {2'b00, 2'(m), 1'b0, u, p, r};
  endfunction

  // returns busy cycles and stall cycles, starting at the negedge after the start
  task automatic measure(input int pre, output int n, output int st);
    n = pre; st = 0;
    while (busy && n < 1000) begin
      if (cpu_stall) st++;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_read(input logic [5:0] a, input string req);
    int s;
    wr(2'd0, {2'b00, a});
    wr(2'd2, ctl(0, 0, 0, 1));
    check(data_q == model[a], req, data_q, model[a]);
    s = 0;
    while (cpu_stall && s < 100) begin s++; @(negedge clk); end
    check(s == 4, "R9 read stall", s, 4);
  endtask

  task automatic attempt(input logic [5:0] a, input logic [7:0] d, input int m, input int gap);
    int n, st;
    bit acc;
    acc = (gap <= 3) && (m != 3);
    wr(2'd0, {2'b00, a});
    wr(2'd1, d);
    wr(2'd2, ctl(m, 1, 0, 0));
    repeat (gap) @(negedge clk);
    wr(2'd2, ctl(m, 0, 1, 0));
    if (acc) begin
      check(!unlock_q, "R4 start clears unlock", unlock_q, 0);
      measure(0, n, st);
      check(n == dur_exp(m), (m == 0) ? "R5 duration" : (m == 1) ? "R6 duration" : "R7 duration",
            n, dur_exp(m));
      check(st == 2, "R10 program stall", st, 2);
      model[a] = prog_exp(m, model[a], d);
    end else begin
      check(!busy && !cpu_stall, (m == 3) ? "R11 reserved ignored" : "R4 late request ignored",
            busy, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n, st, u;
    void'($urandom(32'h1234));
    for (int i = 0; i < 64; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(addr_q == 0 && data_q == 0 && mode_q == 0, "R1 registers", data_q, 0);
    check(!unlock_q && !busy && !cpu_stall, "R1 flags", busy, 0);
    do_read(6'd0, "R1 array erased");
    do_read(6'd63, "R1 array erased top");

    // R2 register writes, select 3 inert
    wr(2'd0, 8'hEA);
    check(addr_q == 6'h2A, "R2 address field", addr_q, 6'h2A);
    wr(2'd1, 8'h5C);
    wr(2'd3, 8'h00);
    check(data_q == 8'h5C && addr_q == 6'h2A, "R2 select 3 inert", data_q, 8'h5C);

    // R3 unlock window length and reload
    wr(2'd2, ctl(0, 1, 0, 0));
    u = 0;
    while (unlock_q && u < 50) begin u++; @(negedge clk); end
    check(u == 4, "R3 window length", u, 4);
    wr(2'd2, ctl(0, 1, 0, 0));
    @(negedge clk); @(negedge clk);
    wr(2'd2, ctl(0, 1, 0, 0));
    u = 0;
    while (unlock_q && u < 50) begin u++; @(negedge clk); end
    check(u == 4, "R3 window reload", u, 4);

    // R4 request with no unlock
    wr(2'd0, 8'd7); wr(2'd1, 8'h00);
    wr(2'd2, ctl(0, 0, 1, 0));
    check(!busy, "R4 no unlock ignored", busy, 0);
    do_read(6'd7, "R4 array unchanged");
    // R4 unlock and request in one write, window closed
    wr(2'd1, 8'h00);
    wr(2'd2, ctl(0, 1, 1, 0));
    check(!busy, "R4 same-write ignored", busy, 0);
    repeat (5) @(negedge clk);

    // R11 reserved mode
    attempt(6'd9, 8'h00, 3, 1);
    check(mode_q == 2'b11, "R11 mode stored", mode_q, 3);
    do_read(6'd9, "R11 array unchanged");

    // R7 write-only on unerased data ANDs
    attempt(6'd3, 8'hF0, 0, 0);
    do_read(6'd3, "R5 combined result");
    attempt(6'd3, 8'h3C, 2, 2);
    do_read(6'd3, "R7 AND result");
    attempt(6'd3, 8'h00, 1, 3);
    do_read(6'd3, "R6 erase result");
    attempt(6'd3, 8'h96, 2, 1);
    do_read(6'd3, "R7 after erase");
    attempt(6'd3, 8'h00, 1, 4);
    do_read(6'd3, "R4 gap 4 ignored");

    // R8 refusal during busy
    wr(2'd0, 8'd20); wr(2'd1, 8'hA5);
    wr(2'd2, ctl(0, 1, 0, 0));
    wr(2'd2, ctl(0, 0, 1, 0));
    wr(2'd0, 8'd21);
    check(addr_q == 20, "R8 address held", addr_q, 20);
    wr(2'd1, 8'h11);
    check(data_q == 8'hA5, "R8 data held", data_q, 8'hA5);
    wr(2'd2, ctl(2, 0, 0, 1));
    check(mode_q == 0 && !cpu_stall, "R8 read refused", mode_q, 0);
    wr(2'd2, ctl(0, 1, 0, 0));
    check(!unlock_q, "R8 unlock refused", unlock_q, 0);
    measure(4, n, st);
    check(n == ER + WR, "R8 R5 duration kept", n, ER + WR);
    model[20] = 8'hA5;
    do_read(6'd20, "R8 R5 result");

    // random mix
    for (int k = 0; k < 60; k++) begin
      logic [5:0] a;
      logic [7:0] d;
      int m, g;
      a = 6'($urandom_range(0, 63));
      d = 8'($urandom);
      m = $urandom_range(0, 3);
      g = $urandom_range(0, 5);
      attempt(a, d, m, g);
      do_read(a, "R2 random readback");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule